// File: doc/BRIEF.md
# Windowed register file

This block is the register file of a processor that passes arguments in registers through overlapping windows. The datapath always addresses 32 registers. Eight of them are globals that every window shares. The other 24 come from the current window, which a pointer selects out of a circular bank. Each window has three groups of eight registers: outs, locals and ins. Only the locals belong to a single window. A window's ins are physically the outs of its neighbour. A call therefore hands the caller's outs to the callee as its ins, and a return hands them back, with no data copied in either direction.

A save command moves the pointer one window down the stack and a restore command moves it one window up. The pointer wraps around the bank, and the window count is a parameter. The block has an external mask that marks windows as invalid. A command whose target window is marked invalid raises a trap flag and leaves the pointer where it is. Trap service and spilling windows to memory are left to the surrounding logic.

Top module: `wreg_file`

## Requirements
- R1: After reset the window pointer is 0, both trap flags are low and every visible register reads 0.
- R2: Visible index 0 always reads 0, and a write to index 0 has no effect.
- R3: Indices 1 to 7 are globals: a value written there reads back unchanged from every window.
- R4: Indices 16 to 23 are locals, private to one window: a write in one window does not change what another window reads at these indices.
- R5: A save with no restore and a valid target sets the pointer to (pointer - 1) mod NWIN, and the caller's outs (indices 8 to 15) then read as the callee's ins (indices 24 to 31).
- R6: A restore with no save and a valid target sets the pointer to (pointer + 1) mod NWIN, and values the callee wrote to its ins then read as the caller's outs.
- R7: A save whose target window has its bit set in win_invalid (bit n marks window n) raises ovf_trap in the same cycle, and the pointer stays unchanged.
- R8: A restore whose target window has its bit set in win_invalid raises unf_trap in the same cycle, and the pointer stays unchanged.
- R9: A save and a restore in the same cycle are both ignored: the pointer holds and neither trap flag rises.
- R10: A write issued in the same cycle as a window move lands in the window that was current before the move.
- R11: Reads are combinational. A read of the index being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R12: The pointer wraps: saves from 0 reach NWIN-1, and restores from NWIN-1 reach 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_data | input | DW | Write data |
| save_i | input | 1 | Move window down (call) |
| restore_i | input | 1 | Move window up (return) |
| win_invalid | input | NWIN | Per-window invalid mask |
| cwp | output | $clog2(NWIN) | Current window pointer |
| ovf_trap | output | 1 | Save blocked by invalid target |
| unf_trap | output | 1 | Restore blocked by invalid target |

## Verification
The bench builds the block with NWIN set to 4 and DW left at 32. With only four windows, a few saves or restores cross the wrap boundary in both directions. Random traffic then regularly revisits windows whose locals and outs already hold data, which exercises the aliasing between one window's ins and its neighbour's outs. A random invalid mask on a share of the cycles causes both traps to occur many times alongside writes and reads.

// File: rtl/wreg_file.sv
`timescale 1ns/1ps
module wreg_file #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4:0]               rd_a_idx,
  output logic [DW-1:0]            rd_a_data,
  input  logic [4:0]               rd_b_idx,
  output logic [DW-1:0]            rd_b_data,
  input  logic                     wr_en,
  input  logic [4:0]               wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic                     save_i,
  input  logic                     restore_i,
  input  logic [NWIN-1:0]          win_invalid,
  output logic [$clog2(NWIN)-1:0]  cwp,
  output logic                     ovf_trap,
  output logic                     unf_trap
);
  localparam int CW    = $clog2(NWIN);
  localparam int PW    = CW + 4;
  localparam int NPHYS = NWIN * 16;

  logic [DW-1:0] glob_q [8];
  logic [DW-1:0] bank_q [NPHYS];
  logic [CW-1:0] cwp_dn, cwp_up;

  assign cwp_dn = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
  assign cwp_up = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;

  assign ovf_trap = save_i & ~restore_i & win_invalid[cwp_dn];
  assign unf_trap = restore_i & ~save_i & win_invalid[cwp_up];

  // ins live in the outs of the window above; locals at offset 0, outs at offset 8
  function automatic logic [PW-1:0] phys(input logic [4:0] r,
                                         input logic [CW-1:0] w,
                                         input logic [CW-1:0] wu);
    logic [CW-1:0] win;
    logic [3:0]    off;
    win = (r[4:3] == 2'b11) ? wu : w;
    off = {(r[4:3] != 2'b10), r[2:0]};
    return {win, off};
  endfunction

  function automatic logic [DW-1:0] rd(input logic [4:0] r);
    if (r[4:3] == 2'b00)
      return (r[2:0] == 3'd0) ? '0 : glob_q[r[2:0]];
    return bank_q[phys(r, cwp, cwp_up)];
  endfunction

  assign rd_a_data = rd(rd_a_idx);
  assign rd_b_data = rd(rd_b_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) glob_q[i] <= '0;
      for (int i = 0; i < NPHYS; i++) bank_q[i] <= '0;
    end else if (wr_en && wr_idx != 5'd0) begin
      if (wr_idx[4:3] == 2'b00) glob_q[wr_idx[2:0]] <= wr_data;
      else bank_q[phys(wr_idx, cwp, cwp_up)] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    cwp <= '0;
    else if (save_i && !restore_i && !ovf_trap)    cwp <= cwp_dn;
    else if (restore_i && !save_i && !unf_trap)    cwp <= cwp_up;
  end
endmodule

// File: rtl/wreg_file_chk.sv
`timescale 1ns/1ps
module wreg_file_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [4:0]              rd_a_idx,
  input logic [DW-1:0]           rd_a_data,
  input logic                    save_i,
  input logic                    restore_i,
  input logic [$clog2(NWIN)-1:0] cwp,
  input logic                    ovf_trap,
  input logic                    unf_trap
);
  localparam int CW = $clog2(NWIN);

  // R2
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 5'd0 |-> rd_a_data == '0);
  // R9
  dual_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |-> (!ovf_trap && !unf_trap));
  // R9
  dual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |=> cwp == $past(cwp));
  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |=> cwp == $past(cwp));
  // R8
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_trap |=> cwp == $past(cwp));
  // R5
  save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && !restore_i && !ovf_trap) |=>
      cwp == (($past(cwp) == '0) ? CW'(NWIN - 1) : $past(cwp) - 1'b1));
  // R6
  restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && !save_i && !unf_trap) |=>
      cwp == (($past(cwp) == CW'(NWIN - 1)) ? '0 : $past(cwp) + 1'b1));
  // R7
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_trap, unf_trap}));
endmodule

bind wreg_file wreg_file_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .save_i(save_i), .restore_i(restore_i), .cwp(cwp),
  .ovf_trap(ovf_trap), .unf_trap(unf_trap)
);

// File: tb/test_wreg_file.sv
`timescale 1ns/1ps
module test_wreg_file;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic wr_en = 1'b0, save_i = 1'b0, restore_i = 1'b0;
  logic [N-1:0] win_invalid = '0;
  logic [1:0] cwp;
  logic ovf_trap, unf_trap;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_g [8];
  logic [31:0] m_loc [N][8];
  logic [31:0] m_out [N][8];
  int m_cwp = 0;

  always #4 clk = ~clk;

  wreg_file #(.NWIN(N), .DW(32)) i_wreg_file (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_i(save_i), .restore_i(restore_i), .win_invalid(win_invalid),
    .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input int r, input int w);
    if (r == 0) return 32'd0;
    if (r < 8) return m_g[r];
    if (r < 16) return m_out[w][r-8];
    if (r < 24) return m_loc[w][r-16];
    return m_out[(w+1)%N][r-24];
  endfunction

  function automatic string region(input int r);
    if (r == 0) return "R2";
    if (r < 8) return "R3";
    if (r < 16) return "R5";
    if (r < 24) return "R4";
    return "R6";
  endfunction

  task automatic step(input string t, input int ra, input int rb,
                      input bit we, input int wi, input logic [31:0] wd,
                      input bit sv, input bit rs, input logic [N-1:0] inv);
    int dn, up;
    @(negedge clk);
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    save_i = sv; restore_i = rs; win_invalid = inv;
    #1;
    dn = (m_cwp + N - 1) % N;
    up = (m_cwp + 1) % N;
    chk(rd_a_data, mread(ra, m_cwp), {t, " R11 read A ", region(ra)});
    chk(rd_b_data, mread(rb, m_cwp), {t, " R11 read B ", region(rb)});
    chk(32'(cwp), 32'(m_cwp), {t, " R12 window pointer"});
    chk(32'(ovf_trap), 32'(sv && !rs && inv[dn]), {t, " R7 overflow flag"});
    chk(32'(unf_trap), 32'(rs && !sv && inv[up]), {t, " R8 underflow flag"});
    if (we && wi != 0) begin
      if (wi < 8) m_g[wi] = wd;
      else if (wi < 16) m_out[m_cwp][wi-8] = wd;
      else if (wi < 24) m_loc[m_cwp][wi-16] = wd;
      else m_out[up][wi-24] = wd;
    end
    if (sv && !rs && !inv[dn]) m_cwp = dn;
    else if (rs && !sv && !inv[up]) m_cwp = up;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_g[i] = '0;
    for (int w = 0; w < N; w++)
      for (int i = 0; i < 8; i++) begin m_loc[w][i] = '0; m_out[w][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of all visible registers
    for (int i = 0; i < 16; i++) step("R1", i, i + 16, 0, 0, 0, 0, 0, '0);
    // R2: write to index 0 discarded
    step("R2", 0, 0, 1, 0, 32'hdead_beef, 0, 0, '0);
    step("R2", 0, 1, 0, 0, 0, 0, 0, '0);
    // R3: globals
    for (int i = 1; i < 8; i++) step("R3", 0, i, 1, i, 32'h100 + 32'(i), 0, 0, '0);
    // R5: fill outs, then save
    for (int i = 8; i < 16; i++) step("R5", i, 0, 1, i, 32'h5000 + 32'(i), 0, 0, '0);
    step("R5", 8, 3, 0, 0, 0, 1, 0, '0);
    for (int i = 24; i < 32; i++) step("R5", i, i - 21, 0, 0, 0, 0, 0, '0);
    // R4: locals in callee, compare after return
    for (int i = 16; i < 24; i++) step("R4", i, 0, 1, i, 32'h4400 + 32'(i), 0, 0, '0);
    // R6: callee writes ins, restore
    for (int i = 24; i < 32; i++) step("R6", i, 0, 1, i, 32'h6600 + 32'(i), 0, 0, '0);
    step("R6", 24, 16, 0, 0, 0, 0, 1, '0);
    for (int i = 8; i < 16; i++) step("R6", i, i + 8, 0, 0, 0, 0, 0, '0);
    // R10: write with move uses pre-move window
    step("R10", 17, 0, 1, 17, 32'haaaa_0001, 1, 0, '0);
    step("R10", 17, 0, 0, 0, 0, 0, 1, '0);
    step("R10", 17, 0, 0, 0, 0, 0, 0, '0);
    // R11: read of index under write shows old value
    step("R11", 20, 20, 1, 20, 32'h1111_2222, 0, 0, '0);
    step("R11", 20, 20, 0, 0, 0, 0, 0, '0);
    // R7: save into invalid window
    step("R7", 8, 0, 0, 0, 0, 1, 0, 4'b1000);
    step("R7", 8, 0, 0, 0, 0, 0, 0, '0);
    // R8: restore into invalid window
    step("R8", 8, 0, 0, 0, 0, 0, 1, 4'b0010);
    step("R8", 8, 0, 0, 0, 0, 0, 0, '0);
    // R9: both commands together
    step("R9", 8, 0, 0, 0, 0, 1, 1, '0);
    step("R9", 8, 0, 0, 0, 0, 1, 1, 4'b1111);
    step("R9", 8, 0, 0, 0, 0, 0, 0, '0);
    // R12: wrap both ways
    for (int i = 0; i < 5; i++) step("R12", 24, 8, 0, 0, 0, 1, 0, '0);
    for (int i = 0; i < 6; i++) step("R12", 24, 8, 0, 0, 0, 0, 1, '0);
    step("R12", 24, 8, 0, 0, 0, 0, 0, '0);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int c;
      logic [N-1:0] inv;
      c = int'($urandom % 3);
      inv = ($urandom % 4 == 0) ? N'($urandom) : '0;
      step("RND", int'($urandom % 32), int'($urandom % 32), bit'($urandom % 2),
           int'($urandom % 32), $urandom, (c == 1) || ($urandom % 16 == 0),
           (c == 2), inv);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule